// File: doc/BRIEF.md
# Donor Set Selector for Floating Scratchpad Blocks

This block keeps a record of which cache sets currently lend a floating scratchpad block, so that a block can later be handed back to a set that wants more cache capacity. Each recorded set also carries a "still in demand" flag. A set whose flag is raised may not give up its block. It stays recorded and is passed over until its flag drops.

When the migration logic asks for a donor, the block scans the record one word of sets per cycle. A word-wide priority encoder finds the lowest eligible set in that word. An eligible set is one that is recorded and whose demand flag is clear. The scan starts at the word after the one that supplied the previous donor and wraps around. For this reason the worst case is one cycle per word, not one cycle per set. The chosen set leaves the record and its flag is cleared. A one-cycle donor pulse carries its index. If no set qualifies, the block raises a one-cycle no-donor pulse instead.

Top module: `floating_block_holder`

## Requirements
- R1: After a synchronous reset, donor_valid, no_donor, enq_overflow and pick_busy are all low, no set is recorded, and every demand flag is clear.
- R2: Set index s belongs to word s / WORD_W, at bit position s % WORD_W. A donor index is reported as {word, bit}.
- R3: An enqueue is ignored if the set is already recorded. An enqueue of a new set while QDEPTH sets are recorded is also ignored, and enq_overflow is high for exactly the cycle after that enqueue is sampled.
- R4: A pick request sampled while no set is recorded gives a no_donor pulse in the following cycle, and no scan takes place.
- R5: A scan begins at the word after the word of the previous donor (word 0 after reset), advances one word per cycle and wraps. Within a word, the lowest eligible bit wins.
- R6: A recorded set whose demand flag is 1 is never chosen and stays recorded.
- R7: When a donor is chosen, donor_valid is high for one cycle with donor_set. That set is removed from the record and its demand flag is cleared.
- R8: Let the request be sampled on edge E0. If the j-th word examined holds the donor, donor_valid is high in the cycle after edge Ej. After 2^SET_W/WORD_W words without a donor, no_donor is high in the cycle after that last edge. pick_busy is high while scanning, and requests made while busy are ignored.
- R9: A demand-flag write in the same cycle that its word is scanned is applied before the priority encode.
- R10: The number of recorded sets never exceeds QDEPTH. Exactly QDEPTH distinct sets can be recorded without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Record a set as holding a floating block |
| enq_set | input | SET_W | Set index to record |
| enq_overflow | output | 1 | Enqueue dropped because the record was full |
| reins_we | input | 1 | Write a demand flag |
| reins_set | input | SET_W | Set whose demand flag is written |
| reins_val | input | 1 | New demand flag value |
| pick_req | input | 1 | Request a donor set |
| pick_busy | output | 1 | Scan in progress |
| donor_valid | output | 1 | One-cycle pulse: donor found |
| donor_set | output | SET_W | Index of the donor set |
| no_donor | output | 1 | One-cycle pulse: no eligible set |

## Verification
The bench builds the block with SET_W=5, WORD_W=8 and QDEPTH=6. With these values there are four words, so a full scan that wraps around and finds nothing ends five cycles after the request. The six-entry record also fills after a handful of enqueues, which makes overflow and re-fill easy to reach. Directed sequences fix the start word, demand-flag skipping and a flag write that lands in the very cycle its word is scanned. After that, random traffic produces collisions between enqueues, flag writes and picks, and these are compared each clock against a behavioural model.

// File: rtl/fbh_pkg.sv
package fbh_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/fbh_occupancy.sv
module fbh_occupancy #(
  parameter int SET_W  = 7,
  parameter int WORD_W = 16,
  parameter int QDEPTH = 128,
  localparam int NSETS  = 1 << SET_W,
  localparam int NWORDS = NSETS / WORD_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WIDX_W = SET_W - BIT_W,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [SET_W-1:0]  enq_set,
  input  logic              rel_en,
  input  logic [SET_W-1:0]  rel_set,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_bits,
  output logic              empty,
  output logic              overflow
);
  logic [WORD_W-1:0] occ_q [NWORDS];
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  logic [WIDX_W-1:0] enq_w, rel_w;
  logic [BIT_W-1:0]  enq_b, rel_b;
  logic              is_member, full, accept, reject;

  assign enq_w = enq_set[SET_W-1:BIT_W];
  assign enq_b = enq_set[BIT_W-1:0];
  assign rel_w = rel_set[SET_W-1:BIT_W];
  assign rel_b = rel_set[BIT_W-1:0];

  assign is_member = occ_q[enq_w][enq_b];
  assign full      = (cnt_q == CNT_W'(QDEPTH));
  assign accept    = enq_valid && !is_member && !full;
  assign reject    = enq_valid && !is_member && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++) occ_q[w] <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (rel_en) occ_q[rel_w][rel_b] <= 1'b0;
      if (accept) occ_q[enq_w][enq_b] <= 1'b1;
      cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(rel_en);
      ovf_q <= reject;
    end
  end

  assign rd_bits  = occ_q[rd_word];
  assign empty    = (cnt_q == '0);
  assign overflow = ovf_q;

  // R10: occupancy bounded by the configured depth
  p_count_cap_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(QDEPTH));

  // R3: a dropped enqueue only follows a full record
  p_overflow_full_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(cnt_q) == CNT_W'(QDEPTH)));

  // R7: a released set was recorded
  p_release_member_r7: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> occ_q[rel_w][rel_b]);
endmodule

// File: rtl/fbh_reins_table.sv
module fbh_reins_table #(
  parameter int SET_W  = 7,
  parameter int WORD_W = 16,
  localparam int NSETS  = 1 << SET_W,
  localparam int NWORDS = NSETS / WORD_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WIDX_W = SET_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_we,
  input  logic [SET_W-1:0]  upd_set,
  input  logic              upd_val,
  input  logic              clr_en,
  input  logic [SET_W-1:0]  clr_set,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_bits
);
  logic [WORD_W-1:0] tbl_q [NWORDS];

  logic [WIDX_W-1:0] upd_w, clr_w;
  logic [BIT_W-1:0]  upd_b, clr_b;

  assign upd_w = upd_set[SET_W-1:BIT_W];
  assign upd_b = upd_set[BIT_W-1:0];
  assign clr_w = clr_set[SET_W-1:BIT_W];
  assign clr_b = clr_set[BIT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++) tbl_q[w] <= '0;
    end else begin
      if (upd_we) tbl_q[upd_w][upd_b] <= upd_val;
      if (clr_en) tbl_q[clr_w][clr_b] <= 1'b0;
    end
  end

  // same-cycle write is visible to the word under scan
  always_comb begin
    rd_bits = tbl_q[rd_word];
    if (upd_we && (upd_w == rd_word)) rd_bits[upd_b] = upd_val;
  end

  // R7: a donor leaves with its demand flag cleared
  p_flag_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (tbl_q[$past(clr_w)][$past(clr_b)] == 1'b0));
endmodule

// File: rtl/fbh_word_pick.sv
module fbh_word_pick #(
  parameter int WORD_W = 16,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] cand,
  output logic              hit,
  output logic [BIT_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (cand[b]) idx = BIT_W'(b);
    end
  end

  assign hit = |cand;
endmodule

// File: rtl/fbh_scan_ctrl.sv
module fbh_scan_ctrl
  import fbh_pkg::*;
#(
  parameter int SET_W  = 7,
  parameter int WORD_W = 16,
  localparam int NSETS  = 1 << SET_W,
  localparam int NWORDS = NSETS / WORD_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WIDX_W = SET_W - BIT_W,
  localparam int SEEN_W = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pick_req,
  input  logic              empty,
  input  logic              hit,
  input  logic [BIT_W-1:0]  hit_bit,
  output logic [WIDX_W-1:0] scan_word,
  output logic              take,
  output logic              busy,
  output logic              donor_valid,
  output logic [SET_W-1:0]  donor_set,
  output logic              no_donor
);
  scan_state_e       state_q;
  logic [WIDX_W-1:0] word_q, last_q;
  logic [SEEN_W-1:0] seen_q;
  logic              dv_q, nd_q;
  logic [SET_W-1:0]  ds_q;

  assign take = (state_q == SCAN_RUN) && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCAN_IDLE;
      word_q  <= '0;
      last_q  <= WIDX_W'(NWORDS - 1);
      seen_q  <= '0;
      dv_q    <= 1'b0;
      nd_q    <= 1'b0;
      ds_q    <= '0;
    end else begin
      dv_q <= 1'b0;
      nd_q <= 1'b0;
      case (state_q)
        SCAN_IDLE: begin
          if (pick_req) begin
            if (empty) begin
              nd_q <= 1'b1;
            end else begin
              state_q <= SCAN_RUN;
              word_q  <= last_q + 1'b1;
              seen_q  <= '0;
            end
          end
        end
        SCAN_RUN: begin
          if (hit) begin
            dv_q    <= 1'b1;
            ds_q    <= {word_q, hit_bit};
            last_q  <= word_q;
            state_q <= SCAN_IDLE;
          end else if (seen_q == SEEN_W'(NWORDS - 1)) begin
            nd_q    <= 1'b1;
            state_q <= SCAN_IDLE;
          end else begin
            word_q <= word_q + 1'b1;
            seen_q <= seen_q + 1'b1;
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign scan_word   = word_q;
  assign busy        = (state_q == SCAN_RUN);
  assign donor_valid = dv_q;
  assign donor_set   = ds_q;
  assign no_donor    = nd_q;

  // R8: a scan never outlasts one pass over the words
  p_scan_bound_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (seen_q < SEEN_W'(NWORDS)));

  // R8: at most one outcome per cycle
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    !(donor_valid && no_donor));

  // R7: donor indication is a single-cycle pulse
  p_donor_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    donor_valid |=> !donor_valid);

  // R8: a donor only comes out of a running scan
  p_donor_from_scan_r8: assert property (@(posedge clk) disable iff (rst)
    donor_valid |-> $past(busy));
endmodule

// File: rtl/floating_block_holder.sv
module floating_block_holder #(
  parameter int SET_W  = 7,
  parameter int WORD_W = 16,
  parameter int QDEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic [SET_W-1:0] enq_set,
  output logic             enq_overflow,
  input  logic             reins_we,
  input  logic [SET_W-1:0] reins_set,
  input  logic             reins_val,
  input  logic             pick_req,
  output logic             pick_busy,
  output logic             donor_valid,
  output logic [SET_W-1:0] donor_set,
  output logic             no_donor
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WIDX_W = SET_W - BIT_W;

  logic [WIDX_W-1:0] scan_word;
  logic [WORD_W-1:0] occ_bits, flag_bits, cand;
  logic              empty, hit, take;
  logic [BIT_W-1:0]  hit_bit;
  logic [SET_W-1:0]  take_set;

  assign cand     = occ_bits & ~flag_bits;
  assign take_set = {scan_word, hit_bit};

  fbh_occupancy #(.SET_W(SET_W), .WORD_W(WORD_W), .QDEPTH(QDEPTH)) i_occ (
    .clk      (clk),
    .rst      (rst),
    .enq_valid(enq_valid),
    .enq_set  (enq_set),
    .rel_en   (take),
    .rel_set  (take_set),
    .rd_word  (scan_word),
    .rd_bits  (occ_bits),
    .empty    (empty),
    .overflow (enq_overflow)
  );

  fbh_reins_table #(.SET_W(SET_W), .WORD_W(WORD_W)) i_flags (
    .clk    (clk),
    .rst    (rst),
    .upd_we (reins_we),
    .upd_set(reins_set),
    .upd_val(reins_val),
    .clr_en (take),
    .clr_set(take_set),
    .rd_word(scan_word),
    .rd_bits(flag_bits)
  );

  fbh_word_pick #(.WORD_W(WORD_W)) i_pick (
    .cand(cand),
    .hit (hit),
    .idx (hit_bit)
  );

  fbh_scan_ctrl #(.SET_W(SET_W), .WORD_W(WORD_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pick_req   (pick_req),
    .empty      (empty),
    .hit        (hit),
    .hit_bit    (hit_bit),
    .scan_word  (scan_word),
    .take       (take),
    .busy       (pick_busy),
    .donor_valid(donor_valid),
    .donor_set  (donor_set),
    .no_donor   (no_donor)
  );
endmodule

// File: tb/test_floating_block_holder.sv
module test_floating_block_holder;
  localparam int SW = 5;
  localparam int WW = 8;
  localparam int QD = 6;
  localparam int NS = 1 << SW;
  localparam int NW = NS / WW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enq_valid = 1'b0;
  logic [SW-1:0] enq_set = '0;
  logic          reins_we = 1'b0;
  logic [SW-1:0] reins_set = '0;
  logic          reins_val = 1'b0;
  logic          pick_req = 1'b0;
  logic          enq_overflow, pick_busy, donor_valid, no_donor;
  logic [SW-1:0] donor_set;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  floating_block_holder #(.SET_W(SW), .WORD_W(WW), .QDEPTH(QD)) i_floating_block_holder (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_set(enq_set), .enq_overflow(enq_overflow),
    .reins_we(reins_we), .reins_set(reins_set), .reins_val(reins_val),
    .pick_req(pick_req), .pick_busy(pick_busy),
    .donor_valid(donor_valid), .donor_set(donor_set), .no_donor(no_donor)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m_occ [NS];
  bit m_flag [NS];
  int m_cnt, m_word, m_seen, m_last;
  bit m_scan;
  bit e_dv, e_nd, e_ov;
  int e_set;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_occ[i] = 0; m_flag[i] = 0; end
      m_cnt = 0; m_scan = 0; m_word = 0; m_seen = 0; m_last = NW - 1;
      e_dv = 0; e_nd = 0; e_ov = 0; e_set = 0;
    end else begin
      bit acc, rej;
      int es, found;
      es = int'(enq_set);
      acc = 0; rej = 0;
      if (enq_valid && !m_occ[es]) begin
        if (m_cnt < QD) acc = 1; else rej = 1;
      end
      e_dv = 0; e_nd = 0; e_ov = rej;
      if (reins_we) m_flag[int'(reins_set)] = reins_val;
      if (m_scan) begin
        found = -1;
        for (int b = 0; b < WW; b++) begin
          if (found < 0 && m_occ[m_word*WW+b] && !m_flag[m_word*WW+b]) found = m_word*WW + b;
        end
        if (found >= 0) begin
          e_dv = 1; e_set = found;
          m_occ[found] = 0; m_flag[found] = 0; m_cnt--;
          m_last = m_word; m_scan = 0;
        end else if (m_seen == NW - 1) begin
          e_nd = 1; m_scan = 0;
        end else begin
          m_word = (m_word + 1) % NW; m_seen++;
        end
      end else if (pick_req) begin
        if (m_cnt == 0) e_nd = 1;
        else begin m_scan = 1; m_word = (m_last + 1) % NW; m_seen = 0; end
      end
      if (acc) begin m_occ[es] = 1; m_cnt++; end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(donor_valid == e_dv, "R7 donor_valid", int'(donor_valid), int'(e_dv));
      if (e_dv) chk(int'(donor_set) == e_set, "R5 donor_set", int'(donor_set), e_set);
      chk(no_donor == e_nd, "R8 no_donor", int'(no_donor), int'(e_nd));
      chk(enq_overflow == e_ov, "R3 enq_overflow", int'(enq_overflow), int'(e_ov));
      chk(pick_busy == m_scan, "R8 pick_busy", int'(pick_busy), int'(m_scan));
    end
  end

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      summary_and_end();
    end
  end

  task automatic enq1(input int s, output bit ov);
    @(negedge clk); #1; enq_valid = 1'b1; enq_set = SW'(s);
    @(negedge clk); #1; enq_valid = 1'b0; ov = enq_overflow;
  endtask

  task automatic flag1(input int s, input bit v);
    @(negedge clk); #1; reins_we = 1'b1; reins_set = SW'(s); reins_val = v;
    @(negedge clk); #1; reins_we = 1'b0;
  endtask

  // kind: 0 none, 1 donor, 2 no donor; lat counted in cycles after the request
  task automatic do_pick(output int kind, output int set, output int lat);
    @(negedge clk); #1; pick_req = 1'b1;
    @(negedge clk); #1; pick_req = 1'b0;
    lat = 1;
    while (!(donor_valid || no_donor) && lat < 20) begin
      @(negedge clk); #1; lat++;
    end
    kind = donor_valid ? 1 : (no_donor ? 2 : 0);
    set = int'(donor_set);
  endtask

  initial begin
    int k, s, l;
    bit ov;
    repeat (3) @(negedge clk);
    #1; rst = 1'b0;
    @(negedge clk); #1;
    // R1: idle after reset
    chk(!donor_valid && !no_donor && !enq_overflow && !pick_busy, "R1 outputs idle",
        int'({donor_valid, no_donor, enq_overflow, pick_busy}), 0);
    do_pick(k, s, l);
    chk(k == 2 && l == 1, "R4 empty pick gives no_donor", k*100 + l, 201);

    enq1(3, ov); enq1(9, ov); enq1(20, ov);
    flag1(3, 1'b1);
    do_pick(k, s, l);
    chk(k == 1 && s == 9, "R6 flagged set 3 skipped, donor 9", s, 9);
    chk(l == 3, "R8 latency second word", l, 3);
    @(negedge clk); #1;
    chk(!donor_valid, "R7 donor pulse one cycle", int'(donor_valid), 0);
    do_pick(k, s, l);
    chk(k == 1 && s == 20 && l == 2, "R5 R2 start after last word, set 20 word2 bit4",
        s*100 + l, 2002);
    do_pick(k, s, l);
    chk(k == 2 && l == NW + 1, "R8 R6 full wrap without donor", k*100 + l, 200 + NW + 1);

    // R9: clear flag of set 3 in the cycle its word is scanned
    @(negedge clk); #1; pick_req = 1'b1;
    @(negedge clk); #1; pick_req = 1'b0;
    @(negedge clk); #1; reins_we = 1'b1; reins_set = SW'(3); reins_val = 1'b0;
    @(negedge clk); #1; reins_we = 1'b0;
    chk(donor_valid && donor_set == 3, "R9 same-cycle flag write seen by scan",
        int'(donor_valid)*100 + int'(donor_set), 103);

    enq1(0, ov); enq1(1, ov); enq1(2, ov); enq1(8, ov); enq1(16, ov); enq1(31, ov);
    chk(!ov, "R10 QDEPTH-th enqueue accepted", int'(ov), 0);
    enq1(5, ov);
    chk(ov, "R3 enqueue to full record dropped", int'(ov), 1);
    do_pick(k, s, l); chk(k == 1 && s == 8 && l == 2, "R5 donor 8", s*100 + l, 802);
    do_pick(k, s, l); chk(k == 1 && s == 16 && l == 2, "R5 donor 16", s*100 + l, 1602);
    do_pick(k, s, l); chk(k == 1 && s == 31 && l == 2, "R5 donor 31", s*100 + l, 3102);
    do_pick(k, s, l); chk(k == 1 && s == 0 && l == 2, "R5 wrap to word0 donor 0", s*100 + l, 2);
    do_pick(k, s, l); chk(k == 1 && s == 1 && l == 5, "R5 R8 donor 1 after wrap", s*100 + l, 105);
    do_pick(k, s, l); chk(k == 1 && s == 2 && l == 5, "R5 R10 donor 2", s*100 + l, 205);
    do_pick(k, s, l); chk(k == 2 && l == 1, "R3 R4 dropped set 5 never recorded", k*100 + l, 201);

    // random traffic, checked every clock by the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      enq_valid = ($urandom_range(0, 1) == 1);
      enq_set   = SW'($urandom_range(0, NS - 1));
      reins_we  = ($urandom_range(0, 9) < 3);
      reins_set = SW'($urandom_range(0, NS - 1));
      reins_val = ($urandom_range(0, 2) == 0);
      pick_req  = ($urandom_range(0, 4) == 0);
    end
    @(negedge clk); #1;
    enq_valid = 1'b0; reins_we = 1'b0; pick_req = 1'b0;
    repeat (10) @(negedge clk);
    summary_and_end();
  end
endmodule